// File: doc/BRIEF.md
# Neighbour Link Clock-Crossing Input

This block is the receive side of one tile in a two-dimensional array of small processors, where every tile runs on a clock of its own. It provides two independent input channels. Each channel holds a first-in first-out store that is written in the link clock domain and read in the local core's clock domain. Read and write pointers cross between the two domains as gray codes through two-flop synchronisers.

A channel takes its words from exactly one of the four nearest neighbours. A two-bit select field, loaded during start-up configuration, picks that neighbour. When a channel's free space runs low, a hold line goes back to the selected neighbour only, so the sender stops before words can be lost. The local core sees an empty flag and stalls its read until a word is present. A word offered while the store is full is not taken, and the writer keeps offering it until there is room.

Top module: `nlink_tile_input`

## Requirements
- R1: After the asynchronous reset (rst_n low), every channel reports rd_empty high, wr_full low, and all nb_hold bits low.
- R2: A rising wr_clk edge with cfg_en high loads cfg_sel into the select field of channel cfg_ch. Select code k (0..3) picks neighbour k: nb_valid[k] and nb_data[16*k +: 16] feed the channel, and the channel's hold goes out on nb_hold[4*ch + k].
- R3: While cfg_en is low, the value on cfg_sel has no effect on any channel's select field.
- R4: A channel stores a word only when the selected neighbour's valid is high at a wr_clk edge. Valid words from neighbours that are not selected never enter it.
- R5: Words leave each channel in the order they were written. rd_data of a channel shows the oldest stored word whenever rd_empty is low, and rd_en high at a rd_clk edge with rd_empty low removes that word.
- R6: A channel holds 32 words. With 32 words stored in the write-domain view, wr_full is high and any word offered is not stored.
- R7: The hold of a channel is high exactly while the write-domain free space is 4 words or fewer (28 or more stored, no reads since). It drives only the selected neighbour's nb_hold bit; the other three bits of that channel stay low.
- R8: A full store, once drained, returns all 32 words unaltered, with no word lost or duplicated.
- R9: rd_empty rises once the last stored word has been read. rd_en while rd_empty is high does not move the read pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Link (write-side) clock |
| rd_clk | input | 1 | Local core (read-side) clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| cfg_en | input | 1 | Configuration enable for the select fields |
| cfg_ch | input | 1 | Channel whose select field is loaded |
| cfg_sel | input | 2 | Neighbour select code to load |
| nb_valid | input | 4 | Word-valid from each of the four neighbours |
| nb_data | input | 64 | Data from the four neighbours, 16 bits each |
| nb_hold | output | 8 | Hold back to neighbour k for channel c at bit 4*c+k |
| wr_full | output | 2 | Per-channel full flag, write domain |
| rd_en | input | 2 | Per-channel read request, read domain |
| rd_data | output | 32 | Per-channel oldest word, 16 bits each |
| rd_empty | output | 2 | Per-channel empty flag, read domain |

## Verification
The bench builds the block with its default parameters: two channels, 16-bit words, 32 entries, and a hold threshold of 4 free words. With a 32-entry store, both the hold threshold and the full boundary can be reached within a few dozen directed writes. Write and read clocks are unrelated (10 ns and 14 ns), so the gray-code crossing is exercised in both directions. The bench also offers words from non-selected neighbours, and writes the select field while it is disabled, to check that these have no effect.

// File: rtl/nlink_pkg.sv
package nlink_pkg;
  localparam int NB_N = 4;
  typedef logic [1:0] nb_sel_t;
endpackage

// File: rtl/nlink_sync.sv
module nlink_sync #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/nlink_cdc_fifo.sv
module nlink_cdc_fifo #(
  parameter int DW        = 16,
  parameter int DEPTH     = 32,
  parameter int HOLD_FREE = 4
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  output logic          wr_full,
  output logic          wr_hold,
  output logic          wr_fire,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_empty,
  output logic          rd_fire
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [PW-1:0] fill_level(input logic [PW-1:0] wb, input logic [PW-1:0] rb);
    return wb - rb;
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wbin, wgray, rbin, rgray;
  logic [PW-1:0] rgray_w, wgray_r;
  logic [PW-1:0] used_w;

  nlink_sync #(.W(PW)) u_r2w (.clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_w));
  nlink_sync #(.W(PW)) u_w2r (.clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_r));

  assign used_w  = fill_level(wbin, from_gray(rgray_w));
  assign wr_full = (used_w == PW'(DEPTH));
  assign wr_hold = (PW'(DEPTH) - used_w) <= PW'(HOLD_FREE);
  assign wr_fire = wr_valid && !wr_full;

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (wr_fire) begin
      wbin  <= wbin + 1'b1;
      wgray <= to_gray(wbin + 1'b1);
    end
  end

  always_ff @(posedge wr_clk) begin
    if (wr_fire) mem[wbin[AW-1:0]] <= wr_data;
  end

  assign rd_empty = (rgray == wgray_r);
  assign rd_fire  = rd_en && !rd_empty;
  assign rd_data  = mem[rbin[AW-1:0]];

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (rd_fire) begin
      rbin  <= rbin + 1'b1;
      rgray <= to_gray(rbin + 1'b1);
    end
  end
endmodule

// File: rtl/nlink_tile_input.sv
module nlink_tile_input #(
  parameter int DW        = 16,
  parameter int DEPTH     = 32,
  parameter int CH_N      = 2,
  parameter int HOLD_FREE = 4,
  localparam int CHW      = (CH_N > 1) ? $clog2(CH_N) : 1,
  localparam int NB       = nlink_pkg::NB_N
) (
  input  logic               wr_clk,
  input  logic               rd_clk,
  input  logic               rst_n,
  input  logic               cfg_en,
  input  logic [CHW-1:0]     cfg_ch,
  input  logic [1:0]         cfg_sel,
  input  logic [NB-1:0]      nb_valid,
  input  logic [NB*DW-1:0]   nb_data,
  output logic [CH_N*NB-1:0] nb_hold,
  output logic [CH_N-1:0]    wr_full,
  input  logic [CH_N-1:0]    rd_en,
  output logic [CH_N*DW-1:0] rd_data,
  output logic [CH_N-1:0]    rd_empty
);
  import nlink_pkg::*;

  logic [CH_N*2-1:0] ch_sel_v;
  logic [CH_N-1:0]   wr_fire_v;
  logic [CH_N-1:0]   rd_fire_v;

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    nb_sel_t       sel;
    logic          ch_valid;
    logic [DW-1:0] ch_data;
    logic          ch_hold;

    always_ff @(posedge wr_clk or negedge rst_n) begin
      if (!rst_n) sel <= '0;
      else if (cfg_en && cfg_ch == CHW'(c)) sel <= cfg_sel;
    end

    assign ch_valid = nb_valid[sel];
    assign ch_data  = nb_data[sel*DW +: DW];
    assign ch_sel_v[2*c +: 2] = sel;
    assign nb_hold[NB*c +: NB] = ch_hold ? (NB'(1) << sel) : '0;

    nlink_cdc_fifo #(.DW(DW), .DEPTH(DEPTH), .HOLD_FREE(HOLD_FREE)) u_fifo (
      .wr_clk  (wr_clk),
      .rd_clk  (rd_clk),
      .rst_n   (rst_n),
      .wr_valid(ch_valid),
      .wr_data (ch_data),
      .wr_full (wr_full[c]),
      .wr_hold (ch_hold),
      .wr_fire (wr_fire_v[c]),
      .rd_en   (rd_en[c]),
      .rd_data (rd_data[DW*c +: DW]),
      .rd_empty(rd_empty[c]),
      .rd_fire (rd_fire_v[c])
    );
  end
endmodule

// File: rtl/nlink_tile_input_chk.sv
module nlink_tile_input_chk #(
  parameter int CH_N = 2,
  parameter int NB   = 4
) (
  input logic               wr_clk,
  input logic               rd_clk,
  input logic               rst_n,
  input logic               cfg_en,
  input logic [CH_N*2-1:0]  ch_sel_v,
  input logic [CH_N*NB-1:0] nb_hold,
  input logic [CH_N-1:0]    wr_full,
  input logic [CH_N-1:0]    wr_fire_v,
  input logic [CH_N-1:0]    rd_empty,
  input logic [CH_N-1:0]    rd_fire_v
);
  for (genvar c = 0; c < CH_N; c++) begin : g_c
    a_r3_sel_frozen: assert property (@(posedge wr_clk) disable iff (!rst_n)
      !cfg_en |=> $stable(ch_sel_v[2*c +: 2]));
    a_r6_no_overflow: assert property (@(posedge wr_clk) disable iff (!rst_n)
      wr_full[c] |-> !wr_fire_v[c]);
    a_r9_no_underflow: assert property (@(posedge rd_clk) disable iff (!rst_n)
      rd_empty[c] |-> !rd_fire_v[c]);
    a_r7_hold_single: assert property (@(posedge wr_clk) disable iff (!rst_n)
      $onehot0(nb_hold[NB*c +: NB]) &&
      ((nb_hold[NB*c +: NB] & ~(NB'(1) << ch_sel_v[2*c +: 2])) == '0));
    a_r7_hold_before_full: assert property (@(posedge wr_clk) disable iff (!rst_n)
      wr_full[c] |-> (nb_hold[NB*c +: NB] != '0));
  end
endmodule

bind nlink_tile_input nlink_tile_input_chk #(.CH_N(CH_N), .NB(NB)) u_chk (
  .wr_clk   (wr_clk),
  .rd_clk   (rd_clk),
  .rst_n    (rst_n),
  .cfg_en   (cfg_en),
  .ch_sel_v (ch_sel_v),
  .nb_hold  (nb_hold),
  .wr_full  (wr_full),
  .wr_fire_v(wr_fire_v),
  .rd_empty (rd_empty),
  .rd_fire_v(rd_fire_v)
);

// File: tb/tb_nlink_tile_input.sv
module tb_nlink_tile_input;
  logic        wr_clk = 0, rd_clk = 0, rst_n = 0;
  logic        cfg_en = 0;
  logic [0:0]  cfg_ch = 0;
  logic [1:0]  cfg_sel = 0;
  logic [3:0]  nb_valid = 0;
  logic [63:0] nb_data = 0;
  logic [7:0]  nb_hold;
  logic [1:0]  wr_full;
  logic [1:0]  rd_en = 0;
  logic [31:0] rd_data;
  logic [1:0]  rd_empty;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 wr_clk = ~wr_clk;
  always #7 rd_clk = ~rd_clk;

  nlink_tile_input dut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .cfg_en(cfg_en),
    .cfg_ch(cfg_ch), .cfg_sel(cfg_sel), .nb_valid(nb_valid), .nb_data(nb_data),
    .nb_hold(nb_hold), .wr_full(wr_full), .rd_en(rd_en), .rd_data(rd_data),
    .rd_empty(rd_empty)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic configure(input bit en, input int ch, input logic [1:0] sel);
    @(negedge wr_clk);
    cfg_en = en; cfg_ch = ch[0]; cfg_sel = sel;
    @(negedge wr_clk);
    cfg_en = 0;
  endtask

  task automatic send(input int nb, input logic [15:0] w);
    @(negedge wr_clk);
    nb_valid = 0; nb_valid[nb] = 1'b1; nb_data[16*nb +: 16] = w;
    @(negedge wr_clk);
    nb_valid = 0;
  endtask

  task automatic settle();
    repeat (8) @(negedge rd_clk);
    repeat (4) @(negedge wr_clk);
  endtask

  task automatic take(input int ch, input logic [15:0] exp, input string req);
    @(negedge rd_clk);
    check(!rd_empty[ch], req, {31'd0, rd_empty[ch]}, 32'd0);
    check(rd_data[16*ch +: 16] == exp, req, {16'd0, rd_data[16*ch +: 16]}, {16'd0, exp});
    rd_en[ch] = 1'b1;
    @(negedge rd_clk);
    rd_en[ch] = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge wr_clk);
    check(rd_empty == 2'b11, "R1 empty", {30'd0, rd_empty}, 32'd3);
    check(wr_full == 2'b00, "R1 full", {30'd0, wr_full}, 32'd0);
    check(nb_hold == 8'd0, "R1 hold", {24'd0, nb_hold}, 32'd0);
  endtask

  task automatic t_select_and_order();
    configure(1, 0, 2'd2);
    configure(1, 1, 2'd1);
    // R4: neighbour 0 offers junk alongside neighbour 2's words
    for (int i = 0; i < 5; i++) begin
      @(negedge wr_clk);
      nb_valid = 4'b0101; nb_data[15:0] = 16'hDEAD; nb_data[47:32] = 16'hA000 + 16'(i);
    end
    @(negedge wr_clk);
    nb_valid = 0;
    settle();
    check(rd_empty[1], "R4 other channel untouched", {31'd0, rd_empty[1]}, 32'd1);
    for (int i = 0; i < 5; i++) take(0, 16'hA000 + 16'(i), "R5 order via select R2");
    settle();
    check(rd_empty[0], "R9 empty after drain", {31'd0, rd_empty[0]}, 32'd1);
    // R9: read request while empty must not advance
    @(negedge rd_clk); rd_en[0] = 1; repeat (3) @(negedge rd_clk); rd_en[0] = 0;
    send(2, 16'h1234);
    settle();
    take(0, 16'h1234, "R9 empty read ignored");
  endtask

  task automatic t_cfg_ignored();
    configure(0, 0, 2'd3);
    send(3, 16'hBEEF);
    settle();
    check(rd_empty[0], "R3 disabled config ignored", {31'd0, rd_empty[0]}, 32'd1);
    send(2, 16'h5A5A);
    settle();
    take(0, 16'h5A5A, "R3 select kept");
  endtask

  task automatic t_fill_hold_full();
    for (int i = 0; i < 27; i++) send(1, 16'h3000 + 16'(i));
    check(nb_hold[5] == 1'b0, "R7 hold low at 5 free", {31'd0, nb_hold[5]}, 32'd0);
    send(1, 16'h3000 + 16'd27);
    check(nb_hold[5] == 1'b1, "R7 hold at 4 free", {31'd0, nb_hold[5]}, 32'd1);
    check(nb_hold[7:4] == 4'b0010, "R7 hold only selected", {28'd0, nb_hold[7:4]}, 32'd2);
    check(nb_hold[3:0] == 4'b0000, "R7 other channel hold", {28'd0, nb_hold[3:0]}, 32'd0);
    for (int i = 28; i < 31; i++) send(1, 16'h3000 + 16'(i));
    check(wr_full[1] == 1'b0, "R6 not full at 31", {31'd0, wr_full[1]}, 32'd0);
    send(1, 16'h3000 + 16'd31);
    check(wr_full[1] == 1'b1, "R6 full at 32", {31'd0, wr_full[1]}, 32'd1);
    // R6: offer a 33rd word for several cycles while full
    @(negedge wr_clk);
    nb_valid[1] = 1; nb_data[31:16] = 16'hFFFF;
    repeat (8) @(negedge wr_clk);
    nb_valid = 0;
    check(wr_full[1] == 1'b1, "R6 stays full", {31'd0, wr_full[1]}, 32'd1);
    settle();
    for (int i = 0; i < 32; i++) take(1, 16'h3000 + 16'(i), "R8 drain intact");
    settle();
    check(rd_empty[1], "R6 extra word not stored", {31'd0, rd_empty[1]}, 32'd1);
    check(wr_full[1] == 1'b0, "R6 full clears", {31'd0, wr_full[1]}, 32'd0);
    check(nb_hold == 8'd0, "R7 hold releases", {24'd0, nb_hold}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge wr_clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge wr_clk);
    t_select_and_order();
    t_cfg_ignored();
    t_fill_hold_full();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge wr_clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule